// File: doc/BRIEF.md
# Keypad Code Lock Controller

This block is the decision core of a keypad door lock. It receives one decoded key event at a time from a 12-key pad (ten digits plus a star key and a hash key), frames each attempt between a star and a hash, and compares the framed digits against a four-digit code held in an internal register. A correct code opens the lock for a fixed number of clock cycles and reports a granted pulse. A wrong or malformed attempt reports a denied pulse and leaves the lock shut.

A fixed five-digit master sequence, framed the same way, does not open the lock. Instead it arms a capture mode in which the next four digits typed replace the stored code. A one-cycle pulse marks the moment the new code takes effect. Keypad scanning, display text and retention of the code across power loss belong to other blocks. The stored code comes back to its default value on every reset.

Top module: `keylock_ctrl`

## Requirements
- R1: After reset, unlock, granted, denied and code_updated are low and the stored code is the digit sequence 2, 3, 4, 5 (first to last entered).
- R2: A key event is taken only in a cycle with key_valid high; key_code values 0 to 9 are digits, 10 is star, 11 is hash, and 12 to 15 are ignored with no effect on the attempt in progress.
- R3: Star, the four stored digits in order, then hash gives a one-cycle granted pulse, and unlock rises in the same cycle, both on the clock edge that samples the hash.
- R4: A hash that closes an attempt that is neither the stored code nor the master sequence (wrong digits, fewer than four, or five digits other than the master) gives a one-cycle denied pulse on the edge that samples it, and unlock stays low. At most one of granted, denied and code_updated is high in any cycle.
- R5: A digit or a hash received while idle (no star first) gives a denied pulse and the controller stays idle.
- R6: A sixth digit after a star aborts the attempt with a denied pulse and returns the controller to idle.
- R7: A star in the middle of an attempt discards the digits taken so far and starts a fresh attempt.
- R8: Unlock stays high for exactly UNLOCK_CYCLES cycles, then the controller returns to idle; key events arriving while unlocked give no pulse and do not change the unlock duration.
- R9: Star, 2 3 4 5 5, hash enters capture mode with no pulse and no unlock; the next four digits become the stored code, code_updated pulses for one cycle on the edge that samples the fourth digit, and later attempts are compared with the new code only.
- R10: A star or a hash during capture mode gives a denied pulse, returns to idle, and leaves the stored code unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_valid | input | 1 | High for one cycle per decoded key event |
| key_code | input | 4 | Key value: 0-9 digit, 10 star, 11 hash |
| unlock | output | 1 | Lock actuator drive, high while open |
| granted | output | 1 | One-cycle pulse on an accepted code |
| denied | output | 1 | One-cycle pulse on a rejected or aborted attempt |
| code_updated | output | 1 | One-cycle pulse when a new code is stored |

## Verification
The hardest state to reach from the ports is capture mode after the stored code has already been replaced, because it needs the exact five-digit master frame followed by a partial new code that is then cut short. The stimulus first replaces the code, proves the old code is now denied and the new one granted, then re-enters capture and aborts it with a star and with a hash, each followed by an attempt with the new code to show nothing was overwritten. Key events sent while the lock is open are checked through the absence of pulses and an unchanged open duration.

// File: rtl/keylock_pkg.sv
package keylock_pkg;

    localparam int KEY_W   = 4;
    localparam int DIGIT_W = 4;

    typedef logic [KEY_W-1:0]   key_t;
    typedef logic [DIGIT_W-1:0] digit_t;

    localparam key_t KEY_STAR = 4'd10;
    localparam key_t KEY_HASH = 4'd11;
    localparam key_t KEY_LAST_DIGIT = 4'd9;

    // classified key event
    typedef enum logic [1:0] {
        KEV_NONE,
        KEV_DIGIT,
        KEV_STAR,
        KEV_HASH
    } kev_e;

    // controller state
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ENTRY,
        ST_OPEN,
        ST_CAPTURE
    } lock_st_e;

endpackage

// File: rtl/keylock_key_decode.sv
module keylock_key_decode
    import keylock_pkg::*;
(
    input  logic   key_valid,
    input  key_t   key_code,
    output kev_e   ev,
    output digit_t digit
);

    always_comb begin
        ev    = KEV_NONE;
        digit = digit_t'(key_code);
        if (key_valid) begin
            if (key_code <= KEY_LAST_DIGIT) begin
                ev = KEV_DIGIT;
            end else if (key_code == KEY_STAR) begin
                ev = KEV_STAR;
            end else if (key_code == KEY_HASH) begin
                ev = KEV_HASH;
            end
        end
    end

endmodule

// File: rtl/keylock_digit_buf.sv
module keylock_digit_buf
    import keylock_pkg::*;
#(
    parameter int MAX_LEN = 5,
    parameter int CNT_W   = $clog2(MAX_LEN + 1)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            clear,
    input  logic                            push,
    input  digit_t                          din,
    output logic [MAX_LEN-1:0][DIGIT_W-1:0] digits,
    output logic [CNT_W-1:0]                count,
    output logic                            full
);

    typedef struct packed {
        logic [MAX_LEN-1:0][DIGIT_W-1:0] dig;
        logic [CNT_W-1:0]                cnt;
    } buf_t;

    buf_t r_q, r_d;

    assign full   = (r_q.cnt == CNT_W'(MAX_LEN));
    assign digits = r_q.dig;
    assign count  = r_q.cnt;

    always_comb begin
        r_d = r_q;
        if (clear) begin
            r_d.cnt = '0;
        end else if (push && !full) begin
            for (int i = 0; i < MAX_LEN; i++) begin
                if (r_q.cnt == CNT_W'(i)) begin
                    r_d.dig[i] = din;
                end
            end
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/keylock_cmp.sv
module keylock_cmp
    import keylock_pkg::*;
#(
    parameter int CODE_LEN = 4,
    parameter int CNT_W    = 3,
    parameter logic [(CODE_LEN+1)*DIGIT_W-1:0] MASTER_CODE = 20'h23455
) (
    input  logic [CODE_LEN:0][DIGIT_W-1:0]   entered,
    input  logic [CNT_W-1:0]                 count,
    input  logic [CODE_LEN-1:0][DIGIT_W-1:0] stored,
    output logic                             user_hit,
    output logic                             master_hit
);

    logic [CODE_LEN-1:0] user_eq;
    logic [CODE_LEN:0]   master_eq;

    // per-digit equality against the stored code
    for (genvar i = 0; i < CODE_LEN; i++) begin : g_user
        assign user_eq[i] = (entered[i] == stored[i]);
    end

    // per-digit equality against the fixed master sequence (first digit in top nibble)
    for (genvar i = 0; i <= CODE_LEN; i++) begin : g_master
        assign master_eq[i] = (entered[i] == MASTER_CODE[(CODE_LEN-i)*DIGIT_W +: DIGIT_W]);
    end

    assign user_hit   = (&user_eq)   && (count == CNT_W'(CODE_LEN));
    assign master_hit = (&master_eq) && (count == CNT_W'(CODE_LEN + 1));

endmodule

// File: rtl/keylock_hold_timer.sv
module keylock_hold_timer #(
    parameter int HOLD = 16,
    parameter int TW   = $clog2(HOLD + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic active,
    output logic last
);

    logic [TW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = TW'(HOLD);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign active = (cnt_q != '0);
    assign last   = (cnt_q == TW'(1));

endmodule

// File: rtl/keylock_ctrl.sv
module keylock_ctrl
    import keylock_pkg::*;
#(
    parameter int CODE_LEN      = 4,
    parameter int UNLOCK_CYCLES = 16,
    parameter logic [CODE_LEN*DIGIT_W-1:0]     DEFAULT_CODE = 16'h2345,
    parameter logic [(CODE_LEN+1)*DIGIT_W-1:0] MASTER_CODE  = 20'h23455
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_valid,
    input  logic [3:0] key_code,
    output logic       unlock,
    output logic       granted,
    output logic       denied,
    output logic       code_updated
);

    localparam int MAX_LEN = CODE_LEN + 1;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    typedef logic [CODE_LEN-1:0][DIGIT_W-1:0] code_t;

    // default code parameter holds the first digit in its top nibble
    function automatic code_t reset_code();
        code_t c;
        for (int i = 0; i < CODE_LEN; i++) begin
            c[i] = DEFAULT_CODE[(CODE_LEN-1-i)*DIGIT_W +: DIGIT_W];
        end
        return c;
    endfunction

    localparam code_t RESET_CODE = reset_code();

    typedef struct packed {
        lock_st_e st;
        code_t    code;
        logic     granted;
        logic     denied;
        logic     updated;
    } ctrl_t;

    ctrl_t r_q, r_d;

    kev_e                            ev;
    digit_t                          ev_digit;
    logic                            buf_clear, buf_push, buf_full;
    logic [MAX_LEN-1:0][DIGIT_W-1:0] buf_digits;
    logic [CNT_W-1:0]                buf_count;
    logic                            user_hit, master_hit;
    logic                            tmr_load, tmr_active, tmr_last;
    code_t                           fresh_code;

    keylock_key_decode u_dec (
        .key_valid (key_valid),
        .key_code  (key_code),
        .ev        (ev),
        .digit     (ev_digit)
    );

    keylock_digit_buf #(
        .MAX_LEN (MAX_LEN),
        .CNT_W   (CNT_W)
    ) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (buf_clear),
        .push   (buf_push),
        .din    (ev_digit),
        .digits (buf_digits),
        .count  (buf_count),
        .full   (buf_full)
    );

    keylock_cmp #(
        .CODE_LEN    (CODE_LEN),
        .CNT_W       (CNT_W),
        .MASTER_CODE (MASTER_CODE)
    ) u_cmp (
        .entered    (buf_digits),
        .count      (buf_count),
        .stored     (r_q.code),
        .user_hit   (user_hit),
        .master_hit (master_hit)
    );

    keylock_hold_timer #(
        .HOLD (UNLOCK_CYCLES)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .active (tmr_active),
        .last   (tmr_last)
    );

    // new code: digits already buffered plus the digit arriving now as the last one
    always_comb begin
        for (int i = 0; i < CODE_LEN; i++) begin
            fresh_code[i] = (i == CODE_LEN - 1) ? ev_digit : buf_digits[i];
        end
    end

    always_comb begin
        r_d         = r_q;
        r_d.granted = 1'b0;
        r_d.denied  = 1'b0;
        r_d.updated = 1'b0;
        buf_clear   = 1'b0;
        buf_push    = 1'b0;
        tmr_load    = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (ev == KEV_STAR) begin
                    r_d.st    = ST_ENTRY;
                    buf_clear = 1'b1;
                end else if (ev == KEV_DIGIT || ev == KEV_HASH) begin
                    r_d.denied = 1'b1;
                end
            end

            ST_ENTRY: begin
                if (ev == KEV_STAR) begin
                    buf_clear = 1'b1;
                end else if (ev == KEV_DIGIT) begin
                    if (buf_full) begin
                        r_d.st     = ST_IDLE;
                        r_d.denied = 1'b1;
                        buf_clear  = 1'b1;
                    end else begin
                        buf_push = 1'b1;
                    end
                end else if (ev == KEV_HASH) begin
                    buf_clear = 1'b1;
                    if (user_hit) begin
                        r_d.st      = ST_OPEN;
                        r_d.granted = 1'b1;
                        tmr_load    = 1'b1;
                    end else if (master_hit) begin
                        r_d.st = ST_CAPTURE;
                    end else begin
                        r_d.st     = ST_IDLE;
                        r_d.denied = 1'b1;
                    end
                end
            end

            ST_OPEN: begin
                if (tmr_last) begin
                    r_d.st = ST_IDLE;
                end
            end

            ST_CAPTURE: begin
                if (ev == KEV_DIGIT) begin
                    if (buf_count == CNT_W'(CODE_LEN - 1)) begin
                        r_d.code    = fresh_code;
                        r_d.updated = 1'b1;
                        r_d.st      = ST_IDLE;
                        buf_clear   = 1'b1;
                    end else begin
                        buf_push = 1'b1;
                    end
                end else if (ev == KEV_STAR || ev == KEV_HASH) begin
                    r_d.st     = ST_IDLE;
                    r_d.denied = 1'b1;
                    buf_clear  = 1'b1;
                end
            end

            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st      <= ST_IDLE;
            r_q.code    <= RESET_CODE;
            r_q.granted <= 1'b0;
            r_q.denied  <= 1'b0;
            r_q.updated <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign unlock       = tmr_active;
    assign granted      = r_q.granted;
    assign denied       = r_q.denied;
    assign code_updated = r_q.updated;

endmodule

// File: rtl/keylock_ctrl_chk.sv
module keylock_ctrl_chk #(
    parameter int HOLD = 16
) (
    input logic clk,
    input logic rst_n,
    input logic unlock,
    input logic granted,
    input logic denied,
    input logic code_updated
);

    localparam int RW = $clog2(HOLD + 2);

    logic [RW-1:0] run_q;

    // consecutive cycles unlock has been high before the current one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (unlock) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    AST_OPEN_WITH_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlock) |-> granted); // R3

    AST_GRANT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        granted |=> !granted); // R3

    AST_ONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({granted, denied, code_updated})); // R4

    AST_DENY_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
        denied |-> !unlock); // R4

    AST_OPEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        unlock |-> (run_q < RW'(HOLD))); // R8

    AST_OPEN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(unlock) |-> (run_q == RW'(HOLD))); // R8

    AST_UPDATE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        code_updated |=> !code_updated); // R9

    AST_UPDATE_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
        code_updated |-> !unlock); // R9

endmodule

bind keylock_ctrl keylock_ctrl_chk #(
    .HOLD (UNLOCK_CYCLES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .unlock       (unlock),
    .granted      (granted),
    .denied       (denied),
    .code_updated (code_updated)
);

// File: tb/keylock_ctrl_test.sv
module keylock_ctrl_test;

    localparam int HOLD = 16;
    localparam int K_GRANT = 0;
    localparam int K_DENY  = 1;
    localparam int K_UPD   = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       key_valid = 1'b0;
    logic [3:0] key_code = 4'd0;
    logic       unlock, granted, denied, code_updated;

    typedef struct {
        int    kind;
        string req;
    } exp_t;

    exp_t expq[$];
    int   checks = 0;
    int   errors = 0;
    int   run = 0;
    bit   mon_en = 1'b0;

    always #5 clk = ~clk;

    keylock_ctrl #(
        .UNLOCK_CYCLES (HOLD)
    ) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .key_valid    (key_valid),
        .key_code     (key_code),
        .unlock       (unlock),
        .granted      (granted),
        .denied       (denied),
        .code_updated (code_updated)
    );

    function automatic string kname(int k);
        case (k)
            K_GRANT: return "granted";
            K_DENY:  return "denied";
            K_UPD:   return "code_updated";
            default: return "none";
        endcase
    endfunction

    task automatic expect_evt(int kind, string req);
        exp_t e;
        e.kind = kind;
        e.req  = req;
        expq.push_back(e);
    endtask

    // '*' star, '#' hash, '0'-'9' digits, 'x' key 13 (unused code), 'v' hash code with valid low
    task automatic keys(string s, int gap = 2);
        for (int i = 0; i < s.len(); i++) begin
            byte c;
            c = s[i];
            @(negedge clk);
            key_valid = 1'b1;
            if (c == "*")      key_code = 4'd10;
            else if (c == "#") key_code = 4'd11;
            else if (c == "x") key_code = 4'd13;
            else if (c == "v") begin
                key_code  = 4'd11;
                key_valid = 1'b0;
            end else           key_code = 4'(c - "0");
            @(negedge clk);
            key_valid = 1'b0;
            key_code  = 4'd0;
            for (int g = 1; g < gap; g++) @(negedge clk);
        end
    endtask

    task automatic drain(string req);
        repeat (HOLD + 4) @(negedge clk);
        checks++;
        if (expq.size() != 0) begin
            errors++;
            $display("FAIL %s: actual none, expected %s pending", expq[0].req, kname(expq[0].kind));
            expq.delete();
        end
        if (req.len() == 0) $display("drain done");
    endtask

    // monitor: pops expected pulses and checks unlock duration
    always @(negedge clk) begin
        if (mon_en) begin
            int n;
            int k;
            n = int'(granted) + int'(denied) + int'(code_updated);
            k = granted ? K_GRANT : (denied ? K_DENY : K_UPD);
            if (n > 1) begin
                checks++;
                errors++;
                $display("FAIL R4: actual %0d status pulses together, expected at most 1", n);
            end else if (n == 1) begin
                checks++;
                if (expq.size() == 0) begin
                    errors++;
                    $display("FAIL R8 unexpected pulse: actual %s, expected none", kname(k));
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    if (e.kind != k) begin
                        errors++;
                        $display("FAIL %s: actual %s, expected %s", e.req, kname(k), kname(e.kind));
                    end
                end
            end
            if (unlock) begin
                run++;
            end else if (run > 0) begin
                checks++;
                if (run != HOLD) begin
                    errors++;
                    $display("FAIL R8: actual unlock length %0d, expected %0d", run, HOLD);
                end
                run = 0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual run still going, expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if ({unlock, granted, denied, code_updated} != 4'b0000) begin
            errors++;
            $display("FAIL R1: actual outputs %b in reset, expected 0000",
                     {unlock, granted, denied, code_updated});
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if ({unlock, granted, denied, code_updated} != 4'b0000) begin
            errors++;
            $display("FAIL R1: actual outputs %b after reset, expected 0000",
                     {unlock, granted, denied, code_updated});
        end
        mon_en = 1'b1;

        // R1 R3: default code opens
        expect_evt(K_GRANT, "R3");
        keys("*2345#");
        drain("R3");

        // R4: wrong, short and non-master five digit attempts
        expect_evt(K_DENY, "R4");
        keys("*1234#");
        expect_evt(K_DENY, "R4");
        keys("*234#");
        expect_evt(K_DENY, "R4");
        keys("*23456#");
        drain("R4");

        // R5: digit and hash without star
        expect_evt(K_DENY, "R5");
        keys("7");
        expect_evt(K_DENY, "R5");
        keys("#");
        drain("R5");

        // R6: sixth digit aborts, trailing hash is then an idle hash
        expect_evt(K_DENY, "R6");
        keys("*234567");
        expect_evt(K_DENY, "R5");
        keys("#");
        drain("R6");

        // R7: star restarts; R8: keys during open ignored
        expect_evt(K_GRANT, "R7");
        keys("*99*2345#");
        keys("*1111#", 1);
        drain("R8");

        // R2: unused code and a hash with valid low have no effect
        expect_evt(K_GRANT, "R2");
        keys("*2x3v45#");
        drain("R2");

        // R9: master sequence then new code 8019
        keys("*23455#");
        expect_evt(K_UPD, "R9");
        keys("8019");
        expect_evt(K_DENY, "R9");
        keys("*2345#");
        expect_evt(K_GRANT, "R9");
        keys("*8019#");
        drain("R9");

        // R10: capture aborted by star, then by hash; code unchanged
        keys("*23455#");
        expect_evt(K_DENY, "R10");
        keys("12*");
        expect_evt(K_GRANT, "R10");
        keys("*8019#");
        drain("R10");
        keys("*23455#");
        expect_evt(K_DENY, "R10");
        keys("3#");
        expect_evt(K_GRANT, "R10");
        keys("*8019#");
        drain("R10");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule